// File: doc/BRIEF.md
# Serial NOR Flash Block-Transfer Engine

This engine copies a run of bytes between a byte-wide memory buffer and a serial NOR flash after one trigger write. Before the trigger, the host presents these settings:

- the flash start address;
- a transfer length;
- the base address of the buffer;
- a lane-mode code and a dummy byte count;
- the address width and the chip select, both shared with the single-command path.

The host then writes a trigger word. That word holds both opcodes, a direction bit and a start bit. The engine lowers the chosen chip select and shifts out the opcode, the address bytes and, for reads, the dummy clocks. It then streams the data phase. Each byte moves over a valid/ready memory port in ascending address order. When the last byte has moved and chip select is released, a sticky completion flag is raised. Software polls that flag and clears it before the next trigger.

The controller is a seven-state machine, with states ST_IDLE, ST_OPCODE, ST_ADDR, ST_DUMMY, ST_DATA, ST_MEM and ST_FINISH.

- ST_IDLE goes to ST_OPCODE on an accepted trigger, or straight to ST_FINISH when the length is zero.
- ST_OPCODE goes to ST_ADDR when the opcode byte is done.
- ST_ADDR repeats once per address byte. After the last address byte, a read goes to ST_DUMMY, or to ST_DATA when the dummy count is zero. A write goes to ST_MEM.
- ST_DUMMY repeats once per dummy byte and then goes to ST_DATA.
- ST_DATA goes to ST_MEM after each byte. On a write, the last byte goes to ST_FINISH instead.
- ST_MEM goes back to ST_DATA on each handshake. On a read, the last handshake goes to ST_FINISH instead.
- ST_FINISH sets the completion flag and returns to ST_IDLE.

A byte shifter below the controller produces the serial clock and lanes. It uses SPI mode 0:

- Outbound lanes change only while the clock is low.
- Inbound lanes are sampled as the clock rises.
- Each clock phase lasts one system cycle.

Top module: `nor_dma_engine`

## Requirements
- R1: A cycle with `trig_we` high and `trig_word[0]` high starts a transfer when the engine is idle. `trig_word[1]` selects the direction: 0 moves data from flash to memory, 1 moves data from memory to flash. `trig_word[23:16]` is the opcode sent on reads and `trig_word[15:8]` the opcode sent on writes. A trigger with bit 0 low causes no flash or memory activity.
- R2: A transfer lowers exactly one chip select, `spi_cs_n[cfg_cs_sel]`. It sends the opcode on lane 0, most significant bit first. It then sends the flash address most significant byte first: 4 bytes when `cfg_addr_4b` is 1, otherwise the low 3 bytes.
- R3: A read inserts `cfg_dummy_bytes` × 8 serial clocks between the address and the data, with every output enable low.
- R4: On reads, `cfg_if_type` selects the lane counts. Code 0 uses 1 address lane and 1 data lane. Code 1 uses 1 and 2, code 2 uses 2 and 2, code 3 uses 1 and 4, and code 4 uses 4 and 4. Codes 5 to 7 act as code 0. With one lane, inbound data arrives on `spi_din[1]`; with w lanes, inbound data arrives on lanes w-1..0. Each clock carries the next most significant bits of the byte, and the highest lane holds the most significant of them.
- R5: Writes always use one lane (`spi_dout[0]`, with `spi_doe` equal to 4'b0001 throughout) and insert no dummy clocks, whatever the lane-mode code and dummy count are.
- R6: The memory port moves one byte per cycle with `mem_valid` and `mem_ready` both high, at `cfg_buf_addr` + 0, 1, 2 and so on in order. `mem_write` is high on reads from flash. The address, data and direction stay stable while the engine waits for `mem_ready`.
- R7: `op_done` rises only after every chip select is high again. It stays high until a `done_clr` pulse, which clears it in the next cycle and takes priority.
- R8: A trigger with `cfg_xfer_len` equal to 0 sets `op_done` within two cycles, with no chip select and no memory request.
- R9: A trigger that arrives while a transfer is running is ignored. The running transfer's opcode, address and data are unchanged, and chip select is lowered only once.
- R10: `spi_sclk` idles low and is high only while a chip select is low. `spi_dout` and `spi_doe` hold steady while `spi_sclk` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_flash_addr | input | 32 | Flash start address |
| cfg_xfer_len | input | LEN_W (28) | Byte count of the transfer |
| cfg_buf_addr | input | ADDR_W (32) | Buffer base address on the memory port |
| cfg_if_type | input | 3 | Lane-mode code for reads |
| cfg_dummy_bytes | input | 4 | Dummy clocks for reads, in units of 8 |
| cfg_addr_4b | input | 1 | 1 selects 4 address bytes, 0 selects 3 |
| cfg_cs_sel | input | CS_W (1) | Chip select index |
| trig_we | input | 1 | Trigger word write strobe |
| trig_word | input | 32 | Trigger word: opcodes, direction and start bit |
| done_clr | input | 1 | Clears the completion flag |
| op_done | output | 1 | Sticky completion flag |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | 1 writes a byte into memory, 0 reads one |
| mem_addr | output | ADDR_W (32) | Memory byte address |
| mem_wdata | output | 8 | Byte written into memory |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rdata | input | 8 | Byte read from memory, valid with `mem_ready` |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | NUM_CS (2) | Active-low chip selects |
| spi_dout | output | 4 | Outbound lane values |
| spi_doe | output | 4 | Outbound lane enables |
| spi_din | input | 4 | Inbound lane values |

## Verification
A wrong state or byte counter in the controller shows up at the ports within one byte time, which is 16 or fewer system cycles. Three signs are possible: the count of rising serial clocks per chip-select window differs from opcode + address + dummy + data, output enables appear during dummy clocks, or a memory handshake goes to an address out of sequence. A shifter whose lane mode is latched wrongly changes the reconstructed address or the bytes written to memory at once. A completion flag that is set early is caught the same cycle by its rise while a chip select is still low. A lost clear is caught one cycle after the clear.

// File: rtl/nor_dma_pkg.sv
package nor_dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_MEM,
        ST_FINISH
    } dma_state_e;

    typedef enum logic [1:0] {
        PHY_TX,
        PHY_RX,
        PHY_DUMMY
    } phy_mode_e;

    typedef enum logic [1:0] {
        LANE_X1,
        LANE_X2,
        LANE_X4
    } lane_e;

    // lane count for the address phase of a read
    function automatic lane_e addr_lane_of(input logic [2:0] ift);
        case (ift)
            3'd2:    return LANE_X2;
            3'd4:    return LANE_X4;
            default: return LANE_X1;
        endcase
    endfunction

    // lane count for the data phase of a read
    function automatic lane_e data_lane_of(input logic [2:0] ift);
        case (ift)
            3'd1, 3'd2: return LANE_X2;
            3'd3, 3'd4: return LANE_X4;
            default:    return LANE_X1;
        endcase
    endfunction

endpackage

// File: rtl/nor_dma_shifter.sv
module nor_dma_shifter
    import nor_dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  phy_mode_e  mode_i,
    input  lane_e      lane_i,
    input  logic [7:0] tx_byte_i,
    input  logic [3:0] din_i,
    output logic       sclk_o,
    output logic [3:0] dout_o,
    output logic [3:0] doe_o,
    output logic [7:0] rx_byte_o,
    output logic       done_o
);

    logic       busy_q;
    logic       phase_q;
    logic [2:0] cnt_q;
    logic [7:0] tx_sh_q;
    logic [7:0] rx_sh_q;
    logic       sclk_q;
    logic       done_q;
    phy_mode_e  mode_q;
    lane_e      lane_q;

    lane_e      lane_eff;
    logic [2:0] step;
    logic [7:0] rx_bits;

    assign lane_eff = (mode_i == PHY_DUMMY) ? LANE_X1 : lane_i;

    always_comb begin
        unique case (lane_q)
            LANE_X2: begin
                step    = 3'd2;
                rx_bits = {6'b0, din_i[1:0]};
                dout_o  = {2'b0, tx_sh_q[7:6]};
            end
            LANE_X4: begin
                step    = 3'd4;
                rx_bits = {4'b0, din_i};
                dout_o  = tx_sh_q[7:4];
            end
            default: begin
                step    = 3'd1;
                rx_bits = {7'b0, din_i[1]};
                dout_o  = {3'b0, tx_sh_q[7]};
            end
        endcase
    end

    always_comb begin
        doe_o = 4'b0000;
        if (busy_q && mode_q == PHY_TX) begin
            unique case (lane_q)
                LANE_X2: doe_o = 4'b0011;
                LANE_X4: doe_o = 4'b1111;
                default: doe_o = 4'b0001;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            phase_q <= 1'b0;
            cnt_q   <= 3'd0;
            tx_sh_q <= 8'h00;
            rx_sh_q <= 8'h00;
            sclk_q  <= 1'b0;
            done_q  <= 1'b0;
            mode_q  <= PHY_TX;
            lane_q  <= LANE_X1;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start_i) begin
                    busy_q  <= 1'b1;
                    phase_q <= 1'b0;
                    mode_q  <= mode_i;
                    lane_q  <= lane_eff;
                    tx_sh_q <= tx_byte_i;
                    unique case (lane_eff)
                        LANE_X2: cnt_q <= 3'd3;
                        LANE_X4: cnt_q <= 3'd1;
                        default: cnt_q <= 3'd7;
                    endcase
                end
            end else if (!phase_q) begin
                // rising serial edge: sample inbound lanes
                sclk_q  <= 1'b1;
                phase_q <= 1'b1;
                rx_sh_q <= (rx_sh_q << step) | rx_bits;
            end else begin
                // falling serial edge: advance outbound lanes
                sclk_q  <= 1'b0;
                phase_q <= 1'b0;
                tx_sh_q <= tx_sh_q << step;
                if (cnt_q == 3'd0) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 3'd1;
                end
            end
        end
    end

    assign sclk_o    = sclk_q;
    assign rx_byte_o = rx_sh_q;
    assign done_o    = done_q;

endmodule

// File: rtl/nor_dma_ctrl.sv
module nor_dma_ctrl
    import nor_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 28,
    parameter int CS_W   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       cfg_flash_addr,
    input  logic [LEN_W-1:0]  cfg_xfer_len,
    input  logic [ADDR_W-1:0] cfg_buf_addr,
    input  logic [2:0]        cfg_if_type,
    input  logic [3:0]        cfg_dummy_bytes,
    input  logic              cfg_addr_4b,
    input  logic [CS_W-1:0]   cfg_cs_sel,
    input  logic              trig_we,
    input  logic [31:0]       trig_word,
    input  logic              done_clr,
    output logic              op_done,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ready,
    input  logic [7:0]        mem_rdata,
    output logic              phy_start,
    output phy_mode_e         phy_mode,
    output lane_e             phy_lane,
    output logic [7:0]        phy_tx,
    input  logic [7:0]        phy_rx,
    input  logic              phy_done,
    output logic              cs_active,
    output logic [CS_W-1:0]   cs_index
);

    dma_state_e        state_q, state_d;
    logic              dir_q;
    logic [7:0]        opcode_q;
    logic [31:0]       addr_sh_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  idx_q;
    logic [ADDR_W-1:0] buf_q;
    logic [2:0]        ift_q;
    logic [3:0]        dummy_q;
    logic [3:0]        cnt_q;
    logic [CS_W-1:0]   cs_q;
    logic [7:0]        data_q;
    logic              kick_q, kick_d;
    logic              op_done_q;
    logic              go;
    logic              last;
    logic              shift_state_d;

    logic unused_trig_bits;
    assign unused_trig_bits = ^{trig_word[31:24], trig_word[7:2]};

    assign go   = trig_we && trig_word[0] && (state_q == ST_IDLE);
    assign last = (idx_q == len_q - LEN_W'(1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go) state_d = (cfg_xfer_len == '0) ? ST_FINISH : ST_OPCODE;
            end
            ST_OPCODE: begin
                if (phy_done) state_d = ST_ADDR;
            end
            ST_ADDR: begin
                if (phy_done && cnt_q == 4'd0) begin
                    if (dir_q)                 state_d = ST_MEM;
                    else if (dummy_q != 4'd0)  state_d = ST_DUMMY;
                    else                       state_d = ST_DATA;
                end
            end
            ST_DUMMY: begin
                if (phy_done && cnt_q == 4'd0) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (phy_done) state_d = (dir_q && last) ? ST_FINISH : ST_MEM;
            end
            ST_MEM: begin
                if (mem_ready) state_d = (!dir_q && last) ? ST_FINISH : ST_DATA;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign shift_state_d = (state_d == ST_OPCODE) || (state_d == ST_ADDR) ||
                           (state_d == ST_DUMMY)  || (state_d == ST_DATA);
    assign kick_d = shift_state_d &&
                    ((state_d != state_q) ||
                     (phy_done && (state_q == ST_ADDR || state_q == ST_DUMMY)));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kick_q    <= 1'b0;
            dir_q     <= 1'b0;
            opcode_q  <= 8'h00;
            addr_sh_q <= 32'h0;
            len_q     <= '0;
            idx_q     <= '0;
            buf_q     <= '0;
            ift_q     <= 3'd0;
            dummy_q   <= 4'd0;
            cnt_q     <= 4'd0;
            cs_q      <= '0;
            data_q    <= 8'h00;
            op_done_q <= 1'b0;
        end else begin
            kick_q <= kick_d;
            if (go) begin
                dir_q     <= trig_word[1];
                opcode_q  <= trig_word[1] ? trig_word[15:8] : trig_word[23:16];
                addr_sh_q <= cfg_addr_4b ? cfg_flash_addr : {cfg_flash_addr[23:0], 8'h00};
                cnt_q     <= cfg_addr_4b ? 4'd3 : 4'd2;
                len_q     <= cfg_xfer_len;
                idx_q     <= '0;
                buf_q     <= cfg_buf_addr;
                ift_q     <= cfg_if_type;
                dummy_q   <= cfg_dummy_bytes;
                cs_q      <= cfg_cs_sel;
            end
            if (state_q == ST_ADDR && phy_done) begin
                addr_sh_q <= {addr_sh_q[23:0], 8'h00};
                cnt_q     <= (cnt_q != 4'd0) ? cnt_q - 4'd1 : dummy_q - 4'd1;
            end
            if (state_q == ST_DUMMY && phy_done && cnt_q != 4'd0) begin
                cnt_q <= cnt_q - 4'd1;
            end
            if (state_q == ST_DATA && phy_done) begin
                if (!dir_q)     data_q <= phy_rx;
                else if (!last) idx_q  <= idx_q + LEN_W'(1);
            end
            if (state_q == ST_MEM && mem_ready) begin
                if (dir_q)      data_q <= mem_rdata;
                else if (!last) idx_q  <= idx_q + LEN_W'(1);
            end
            if (done_clr)                    op_done_q <= 1'b0;
            else if (state_q == ST_FINISH)   op_done_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        phy_mode = PHY_TX;
        phy_lane = LANE_X1;
        phy_tx   = opcode_q;
        unique case (state_q)
            ST_ADDR: begin
                phy_tx   = addr_sh_q[31:24];
                phy_lane = dir_q ? LANE_X1 : addr_lane_of(ift_q);
            end
            ST_DUMMY: begin
                phy_mode = PHY_DUMMY;
            end
            ST_DATA: begin
                phy_tx   = data_q;
                phy_mode = dir_q ? PHY_TX : PHY_RX;
                phy_lane = dir_q ? LANE_X1 : data_lane_of(ift_q);
            end
            default: begin
                phy_tx = opcode_q;
            end
        endcase
    end

    assign phy_start = kick_q;
    assign cs_active = (state_q != ST_IDLE) && (state_q != ST_FINISH);
    assign cs_index  = cs_q;
    assign mem_valid = (state_q == ST_MEM);
    assign mem_write = !dir_q;
    assign mem_addr  = buf_q + ADDR_W'(idx_q);
    assign mem_wdata = data_q;
    assign op_done   = op_done_q;

endmodule

// File: rtl/nor_dma_engine.sv
module nor_dma_engine
    import nor_dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 28,
    parameter int NUM_CS = 2,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       cfg_flash_addr,
    input  logic [LEN_W-1:0]  cfg_xfer_len,
    input  logic [ADDR_W-1:0] cfg_buf_addr,
    input  logic [2:0]        cfg_if_type,
    input  logic [3:0]        cfg_dummy_bytes,
    input  logic              cfg_addr_4b,
    input  logic [CS_W-1:0]   cfg_cs_sel,
    input  logic              trig_we,
    input  logic [31:0]       trig_word,
    input  logic              done_clr,
    output logic              op_done,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic              mem_ready,
    input  logic [7:0]        mem_rdata,
    output logic              spi_sclk,
    output logic [NUM_CS-1:0] spi_cs_n,
    output logic [3:0]        spi_dout,
    output logic [3:0]        spi_doe,
    input  logic [3:0]        spi_din
);

    logic            phy_start;
    phy_mode_e       phy_mode;
    lane_e           phy_lane;
    logic [7:0]      phy_tx;
    logic [7:0]      phy_rx;
    logic            phy_done;
    logic            cs_active;
    logic [CS_W-1:0] cs_index;

    nor_dma_ctrl #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .CS_W   (CS_W)
    ) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_flash_addr  (cfg_flash_addr),
        .cfg_xfer_len    (cfg_xfer_len),
        .cfg_buf_addr    (cfg_buf_addr),
        .cfg_if_type     (cfg_if_type),
        .cfg_dummy_bytes (cfg_dummy_bytes),
        .cfg_addr_4b     (cfg_addr_4b),
        .cfg_cs_sel      (cfg_cs_sel),
        .trig_we         (trig_we),
        .trig_word       (trig_word),
        .done_clr        (done_clr),
        .op_done         (op_done),
        .mem_valid       (mem_valid),
        .mem_write       (mem_write),
        .mem_addr        (mem_addr),
        .mem_wdata       (mem_wdata),
        .mem_ready       (mem_ready),
        .mem_rdata       (mem_rdata),
        .phy_start       (phy_start),
        .phy_mode        (phy_mode),
        .phy_lane        (phy_lane),
        .phy_tx          (phy_tx),
        .phy_rx          (phy_rx),
        .phy_done        (phy_done),
        .cs_active       (cs_active),
        .cs_index        (cs_index)
    );

    nor_dma_shifter u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (phy_start),
        .mode_i    (phy_mode),
        .lane_i    (phy_lane),
        .tx_byte_i (phy_tx),
        .din_i     (spi_din),
        .sclk_o    (spi_sclk),
        .dout_o    (spi_dout),
        .doe_o     (spi_doe),
        .rx_byte_o (phy_rx),
        .done_o    (phy_done)
    );

    // one active-low select per attached flash
    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign spi_cs_n[g] = !(cs_active && (cs_index == CS_W'(g)));
    end

endmodule

// File: rtl/nor_dma_checker.sv
module nor_dma_checker #(
    parameter int ADDR_W = 32,
    parameter int NUM_CS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done_clr,
    input logic              op_done,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              mem_write,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        mem_wdata,
    input logic              spi_sclk,
    input logic [NUM_CS-1:0] spi_cs_n,
    input logic [3:0]        spi_dout,
    input logic [3:0]        spi_doe
);

    p_one_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~spi_cs_n) <= 1);

    p_mem_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                       $stable(mem_write) && $stable(mem_wdata)));

    p_done_after_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(op_done) |-> (&spi_cs_n && !mem_valid));

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_clr |=> !op_done);

    p_sclk_in_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> !(&spi_cs_n));

    p_lanes_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> ($stable(spi_dout) && $stable(spi_doe)));

endmodule

bind nor_dma_engine nor_dma_checker #(
    .ADDR_W (ADDR_W),
    .NUM_CS (NUM_CS)
) u_nor_dma_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .done_clr  (done_clr),
    .op_done   (op_done),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_write (mem_write),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .spi_sclk  (spi_sclk),
    .spi_cs_n  (spi_cs_n),
    .spi_dout  (spi_dout),
    .spi_doe   (spi_doe)
);

// File: tb/nor_dma_engine_bench.sv
module nor_dma_engine_bench;

    localparam int CLK_PERIOD = 10;
    localparam int BUF_BASE   = 32'h40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_flash_addr = '0;
    logic [27:0] cfg_xfer_len = '0;
    logic [31:0] cfg_buf_addr = BUF_BASE;
    logic [2:0]  cfg_if_type = '0;
    logic [3:0]  cfg_dummy_bytes = '0;
    logic        cfg_addr_4b = 1'b0;
    logic [0:0]  cfg_cs_sel = '0;
    logic        trig_we = 1'b0;
    logic [31:0] trig_word = '0;
    logic        done_clr = 1'b0;
    logic        op_done;
    logic        mem_valid, mem_write;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_ready = 1'b0;
    logic [7:0]  mem_rdata;
    logic        spi_sclk;
    logic [1:0]  spi_cs_n;
    logic [3:0]  spi_dout, spi_doe;
    logic [3:0]  spi_din = 4'h0;

    nor_dma_engine u_nor_dma_engine (
        .clk(clk), .rst_n(rst_n),
        .cfg_flash_addr(cfg_flash_addr), .cfg_xfer_len(cfg_xfer_len),
        .cfg_buf_addr(cfg_buf_addr), .cfg_if_type(cfg_if_type),
        .cfg_dummy_bytes(cfg_dummy_bytes), .cfg_addr_4b(cfg_addr_4b),
        .cfg_cs_sel(cfg_cs_sel), .trig_we(trig_we), .trig_word(trig_word),
        .done_clr(done_clr), .op_done(op_done),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_dout(spi_dout),
        .spi_doe(spi_doe), .spi_din(spi_din)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;

    // memory model and access log
    logic [7:0] mem [0:255];
    logic [7:0] acc [0:255];
    int         nacc = 0;
    logic       stall_ph = 1'b0;
    assign mem_rdata = mem[mem_addr[7:0]];

    always @(negedge clk) begin
        stall_ph  = ~stall_ph;
        mem_ready = mem_valid && stall_ph;
    end

    always @(posedge clk) begin
        if (mem_valid && mem_ready) begin
            if (mem_write) mem[mem_addr[7:0]] = mem_wdata;
            acc[nacc[7:0]] = mem_addr[7:0];
            nacc++;
        end
    end

    // flash-side monitor and responder
    logic [3:0] log_do [0:1023];
    logic [3:0] log_oe [0:1023];
    int         ncyc = 0;
    int         csf = 0;
    int         last_cs = -1;
    int         rd_prefix = 0;
    int         rd_dw = 1;
    int         rd_n = 0;
    logic [7:0] exp_data [0:31];

    always @(posedge spi_sclk) begin
        log_do[ncyc[9:0]] = spi_dout;
        log_oe[ncyc[9:0]] = spi_doe;
        ncyc++;
    end

    always @(negedge spi_cs_n[0]) begin csf++; last_cs = 0; end
    always @(negedge spi_cs_n[1]) begin csf++; last_cs = 1; end

    function automatic logic [3:0] din_for(input int k);
        int j, per, b, pos;
        logic [7:0] bits;
        if (k < rd_prefix) return 4'h0;
        j   = k - rd_prefix;
        per = 8 / rd_dw;
        b   = j / per;
        pos = j % per;
        if (b >= rd_n) return 4'h0;
        bits = (exp_data[b] >> (8 - rd_dw * (pos + 1))) & ((8'd1 << rd_dw) - 8'd1);
        if (rd_dw == 1) return {2'b00, bits[0], 1'b0};
        return bits[3:0];
    endfunction

    always @(negedge spi_sclk) begin
        #1;
        spi_din = din_for(ncyc);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic int lanes_of_addr(input logic [2:0] ift);
        if (ift == 3'd2) return 2;
        if (ift == 3'd4) return 4;
        return 1;
    endfunction

    function automatic int lanes_of_data(input logic [2:0] ift);
        if (ift == 3'd1 || ift == 3'd2) return 2;
        if (ift == 3'd3 || ift == 3'd4) return 4;
        return 1;
    endfunction

    function automatic logic [3:0] chunk(input logic [3:0] v, input int w);
        if (w == 1) return {3'b0, v[0]};
        if (w == 2) return {2'b0, v[1:0]};
        return v;
    endfunction

    task automatic clear_flags();
        @(negedge clk);
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
        ncyc = 0; csf = 0; nacc = 0; last_cs = -1;
        spi_din = 4'h0;
    endtask

    task automatic fire(input logic [31:0] w);
        @(negedge clk);
        trig_we   = 1'b1;
        trig_word = w;
        @(negedge clk);
        trig_we   = 1'b0;
    endtask

    task automatic wait_done(input string req);
        bit seen = 0;
        for (int i = 0; i < 8000; i++) begin
            @(negedge clk);
            if (op_done) begin seen = 1; break; end
        end
        chk(seen, req, "op_done after transfer", longint'(seen), 1);
    endtask

    // checks opcode (lane 0, MSB first) and address; returns next log cycle
    task automatic chk_header(input logic [7:0] op, input logic [31:0] fa,
                              input bit a4, input int aw, output int k);
        logic [7:0]  got_op = 8'h00;
        logic [31:0] got_a = 32'h0;
        logic [31:0] expa;
        bit          oe_ok = 1;
        int nab = a4 ? 4 : 3;
        for (int i = 0; i < 8; i++) begin
            got_op = {got_op[6:0], log_do[i][0]};
            if (log_oe[i] != 4'b0001) oe_ok = 0;
        end
        chk(got_op == op, "R1", "opcode sent", got_op, op);
        chk(oe_ok, "R2", "opcode on lane 0 only", 0, 1);
        k = 8;
        for (int i = 0; i < nab * 8 / aw; i++) begin
            got_a = (got_a << aw) | 32'(chunk(log_do[k], aw));
            k++;
        end
        expa = a4 ? fa : {8'h00, fa[23:0]};
        chk(got_a == expa, "R2", "flash address", got_a, expa);
    endtask

    task automatic run_read(input logic [2:0] ift, input bit a4, input logic [3:0] dmy,
                            input int n, input int cs, input logic [31:0] fa,
                            input logic [7:0] rop, input logic [7:0] seed, input bit poke);
        int aw = lanes_of_addr(ift);
        int k;
        bit ok;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        for (int j = 0; j < n; j++) exp_data[j] = seed + 8'(j * 37);
        rd_dw = lanes_of_data(ift);
        rd_n = n;
        rd_prefix = 8 + (a4 ? 32 : 24) / aw + int'(dmy) * 8;
        clear_flags();
        cfg_if_type = ift; cfg_addr_4b = a4; cfg_dummy_bytes = dmy;
        cfg_xfer_len = 28'(n); cfg_cs_sel = 1'(cs); cfg_flash_addr = fa;
        fire({8'h00, rop, 8'h02, 6'b0, 1'b0, 1'b1});
        if (poke) begin
            repeat (20) @(negedge clk);
            fire({8'h00, 8'hEE, 8'hDD, 6'b0, 1'b1, 1'b1}); // R9: ignored while busy
        end
        wait_done("R7");
        chk_header(rop, fa, a4, aw, k);
        ok = 1;
        for (int i = 0; i < int'(dmy) * 8; i++) begin
            if (log_oe[k] != 4'b0000) ok = 0;
            k++;
        end
        chk(ok, "R3", "outputs released during dummy clocks", 0, 1);
        chk(ncyc == rd_prefix + n * 8 / rd_dw, "R4", "serial clocks in read",
            ncyc, rd_prefix + n * 8 / rd_dw);
        ok = 1;
        for (int j = 0; j < n; j++) begin
            if (mem[BUF_BASE + j] != exp_data[j]) begin
                ok = 0;
                chk(0, "R4", "byte stored in memory", mem[BUF_BASE + j], exp_data[j]);
            end
        end
        if (ok) chk(1, "R4", "bytes stored in memory", 0, 0);
        ok = (nacc == n);
        for (int j = 0; j < n && j < nacc; j++)
            if (acc[j] != 8'(BUF_BASE + j)) ok = 0;
        chk(ok, "R6", "ascending memory writes", nacc, n);
        chk(last_cs == cs && csf == 1, "R2", "selected chip", last_cs, cs);
        if (poke) chk(csf == 1, "R9", "single frame despite busy trigger", csf, 1);
        chk(&spi_cs_n && op_done, "R7", "done with select released", {spi_cs_n, op_done}, 3'b111);
    endtask

    task automatic run_write(input logic [2:0] ift, input bit a4, input int n,
                             input logic [31:0] fa, input logic [7:0] wop);
        int k;
        bit ok;
        logic [7:0] b;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 13 + 5);
        rd_n = 0; rd_prefix = 0; rd_dw = 1;
        clear_flags();
        cfg_if_type = ift; cfg_addr_4b = a4; cfg_dummy_bytes = 4'd3;
        cfg_xfer_len = 28'(n); cfg_cs_sel = 1'b0; cfg_flash_addr = fa;
        fire({8'h00, 8'h0B, wop, 6'b0, 1'b1, 1'b1});
        wait_done("R7");
        chk_header(wop, fa, a4, 1, k);
        chk(ncyc == 8 + (a4 ? 32 : 24) + n * 8, "R5", "write clocks without dummy",
            ncyc, 8 + (a4 ? 32 : 24) + n * 8);
        ok = 1;
        for (int i = 0; i < ncyc && i < 1024; i++) if (log_oe[i] != 4'b0001) ok = 0;
        chk(ok, "R5", "single lane enable throughout write", 0, 1);
        ok = 1;
        for (int j = 0; j < n; j++) begin
            b = 8'h00;
            for (int i = 0; i < 8; i++) begin b = {b[6:0], log_do[k][0]}; k++; end
            if (b != mem[BUF_BASE + j]) begin
                ok = 0;
                chk(0, "R5", "byte sent to flash", b, mem[BUF_BASE + j]);
            end
        end
        if (ok) chk(1, "R5", "bytes sent to flash", 0, 0);
        ok = (nacc == n);
        for (int j = 0; j < n && j < nacc; j++)
            if (acc[j] != 8'(BUF_BASE + j)) ok = 0;
        chk(ok, "R6", "ascending memory reads", nacc, n);
    endtask

    task automatic t_reset();
        chk(op_done == 1'b0, "R7", "op_done after reset", op_done, 0);
        chk(&spi_cs_n, "R10", "selects idle high", spi_cs_n, 2'b11);
        chk(spi_sclk == 1'b0, "R10", "clock idles low", spi_sclk, 0);
        chk(mem_valid == 1'b0, "R6", "no memory request at reset", mem_valid, 0);
    endtask

    task automatic t_zero_len();
        clear_flags();
        cfg_xfer_len = '0;
        fire({8'h00, 8'h03, 8'h02, 6'b0, 1'b0, 1'b1});
        // trigger sampled at the edge before this negedge; done one edge later
        @(negedge clk);
        chk(op_done == 1'b1, "R8", "zero length completes", op_done, 1);
        chk(csf == 0 && nacc == 0 && ncyc == 0, "R8", "no flash or memory activity",
            csf + nacc + ncyc, 0);
        @(negedge clk);
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
        chk(op_done == 1'b0, "R7", "clear drops op_done", op_done, 0);
    endtask

    task automatic t_no_start();
        clear_flags();
        cfg_xfer_len = 28'd4;
        fire({8'h00, 8'h03, 8'h02, 6'b0, 1'b0, 1'b0});
        repeat (60) @(negedge clk);
        chk(op_done == 1'b0 && csf == 0 && nacc == 0, "R1", "start bit low ignored",
            {op_done, 8'(csf), 8'(nacc)}, 0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 190000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        run_read(3'd0, 1'b0, 4'd1, 4, 0, 32'h0012_3456, 8'h0B, 8'h11, 1'b0);
        run_read(3'd1, 1'b0, 4'd1, 5, 1, 32'h00AB_CDEF, 8'h3B, 8'h22, 1'b0);
        run_read(3'd2, 1'b1, 4'd1, 6, 0, 32'h1234_5678, 8'hBB, 8'h5A, 1'b0);
        run_read(3'd3, 1'b0, 4'd1, 7, 1, 32'h0076_5432, 8'h6B, 8'h93, 1'b0);
        run_read(3'd4, 1'b1, 4'd2, 8, 0, 32'hFEDC_BA98, 8'hEB, 8'hC4, 1'b0);
        run_read(3'd7, 1'b0, 4'd0, 3, 0, 32'h0000_0100, 8'h03, 8'h01, 1'b0);
        run_read(3'd0, 1'b0, 4'd0, 6, 1, 32'h000A_0B0C, 8'h03, 8'h77, 1'b1);
        run_write(3'd4, 1'b0, 5, 32'h0011_2233, 8'h02);
        run_write(3'd0, 1'b1, 8, 32'h8899_AABB, 8'h12);
        t_zero_len();
        t_no_start();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule